// File: doc/BRIEF.md
# Network interface message framer

This block sits between a local port (a processor-side or memory-side unit) and one wormhole network link, with a transmit half and a receive half. On transmit, the local side issues a command that carries a message type, a physical address, a total word count and four spare function bits. The block builds a 32-bit heading from these fields and its own node identifier. It then sends the heading followed by the payload words, one word per flit.

The destination node is taken from the physical address. With `numa_mode` low it is the bottom eight address bits. With `numa_mode` high it is the top eight. The length field counts every word of the message, heading included. A block request is therefore two words long (heading plus a module-relative address). A block reply with `s` block words is `2+s` words long (heading, outcome word, block words).

On receive, the block checks each heading against the local node identifier and a minimum length of two. A good heading has its fields reported to the local side, and the block then delivers the payload words with a marker on the last one. A bad heading raises an error pulse, and the rest of that packet is consumed silently. Both link directions use a level-transition handshake: the sender toggles its ready line for each new flit, and the receiver toggles its acknowledge line once it has taken the flit.

Top module: `nif_framer`

## Requirements
- R1: The first flit of every transmitted message is the heading with message type in bits [31:28], the local `node_id` in [27:20], the destination in [19:12], `cmd_len` in [11:4] and `cmd_func` in [3:0].
- R2: The heading destination is `cmd_addr[7:0]` when `numa_mode` is 0 and `cmd_addr[31:24]` when `numa_mode` is 1.
- R3: After the heading the transmitter sends exactly `cmd_len-1` payload words, taken from `pay_data` in order. A `cmd_len` of 0 or 1 sends the heading alone.
- R4: Each new transmit flit is announced by toggling `tx_rdy`. `tx_rdy` and `tx_data` stay unchanged while `tx_rdy` differs from `tx_ack`.
- R5: After reset `cmd_ready`=1, `tx_rdy`=0 and `rx_ack`=0. `cmd_ready` stays 0 from the accepted command until the acknowledge of the message's last flit has arrived.
- R6: A receive flit is pending while `rx_rdy` differs from `rx_ack`. The block consumes it at the next clock edge and toggles `rx_ack` there, so a pending flit is acknowledged one cycle after it appears.
- R7: A received heading with length of at least 2 and destination equal to `node_id` produces a one-cycle `hdr_valid` with `hdr_type`, `hdr_src`, `hdr_len` and `hdr_func` taken from bits [31:28], [27:20], [11:4] and [3:0].
- R8: The `len-1` flits that follow a good heading each produce one `word_valid` pulse carrying the flit in `word_data`, with `word_last`=1 on the final one only.
- R9: A received heading with length below 2 produces an `err_valid` pulse with `err_code` bit 0 set, and no word pulses. The next flit is treated as a new heading.
- R10: A heading with length of at least 2 whose destination differs from `node_id` produces `err_valid` with `err_code`=2'b10. Its following `len-1` flits are acknowledged but produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | Identifier of this node |
| numa_mode | input | 1 | 0: destination from low address bits, 1: from high address bits |
| cmd_valid | input | 1 | Local command present |
| cmd_ready | output | 1 | Transmitter idle and able to take a command |
| cmd_type | input | 4 | Message type |
| cmd_addr | input | 32 | Physical address used to pick the destination |
| cmd_len | input | 8 | Total message words including heading |
| cmd_func | input | 4 | Spare function bits |
| pay_valid | input | 1 | Payload word present |
| pay_ready | output | 1 | Payload word taken at this edge when valid |
| pay_data | input | 32 | Payload word |
| tx_data | output | 32 | Outgoing flit |
| tx_rdy | output | 1 | Outgoing ready level, toggles per flit |
| tx_ack | input | 1 | Acknowledge level from the network |
| rx_data | input | 32 | Incoming flit |
| rx_rdy | input | 1 | Incoming ready level, toggles per flit |
| rx_ack | output | 1 | Acknowledge level to the network |
| hdr_valid | output | 1 | Pulse: good heading received |
| hdr_type | output | 4 | Received message type |
| hdr_src | output | 8 | Received source identifier |
| hdr_len | output | 8 | Received message length |
| hdr_func | output | 4 | Received function bits |
| word_valid | output | 1 | Pulse: payload word delivered |
| word_data | output | 32 | Delivered payload word |
| word_last | output | 1 | Delivered word is the last of its message |
| err_valid | output | 1 | Pulse: heading rejected |
| err_code | output | 2 | Bit 0 length too short, bit 1 destination mismatch |

## Verification
The bench targets the length edge cases: messages of length 0 and 1 must leave as a bare heading, and a design that subtracted one without a floor would wrap its counter and stream a long run of spurious flits. Both address modes are checked against distinct high and low address bytes, so taking the wrong end shows up as a wrong destination field. It also holds acknowledges back for several cycles, which catches a transmitter that moves to the next word early or frees the command port before the last acknowledge. On receive, a rejected packet with a payload followed by a good packet shows whether dropped words leak out as deliveries, and whether the receiver falls out of step on where the next heading starts.

// File: rtl/nif_pkg.sv
package nif_pkg;
  localparam int TYPE_W  = 4;
  localparam int ID_W    = 8;
  localparam int LEN_W   = 8;
  localparam int FUNC_W  = 4;
  localparam int FLIT_W  = TYPE_W + 2 * ID_W + LEN_W + FUNC_W;
  localparam int MIN_LEN = 2;

  // heading layout, most significant field first
  typedef struct packed {
    logic [TYPE_W-1:0] mtype;
    logic [ID_W-1:0]   src;
    logic [ID_W-1:0]   dst;
    logic [LEN_W-1:0]  len;
    logic [FUNC_W-1:0] func;
  } head_t;

  typedef enum logic [1:0] {
    RX_HEAD = 2'd0,
    RX_BODY = 2'd1,
    RX_DROP = 2'd2
  } rx_state_t;
endpackage

// File: rtl/nif_dest_pick.sv
module nif_dest_pick
  import nif_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              numa,
  output logic [ID_W-1:0]   dst
);
  generate
    if (ADDR_W > ID_W) begin : g_wide
      logic unused_mid;
      assign unused_mid = ^addr;
      assign dst = numa ? addr[ADDR_W-1 -: ID_W] : addr[ID_W-1:0];
    end else if (ADDR_W == ID_W) begin : g_same
      logic unused_mode;
      assign unused_mode = numa;
      assign dst = addr;
    end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = numa;
      assign dst = {{(ID_W - ADDR_W){1'b0}}, addr};
    end
  endgenerate
endmodule

// File: rtl/nif_tx.sv
module nif_tx
  import nif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [ID_W-1:0]   cmd_dst,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [FLIT_W-1:0] pay_data,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_rdy,
  input  logic              tx_ack
);
  logic              busy_q;
  logic              rdy_q;
  logic [LEN_W-1:0]  left_q;
  logic [FLIT_W-1:0] flit_q;
  logic              link_idle;
  head_t             head;

  assign link_idle = (rdy_q == tx_ack);

  always_comb begin
    head.mtype = cmd_type;
    head.src   = node_id;
    head.dst   = cmd_dst;
    head.len   = cmd_len;
    head.func  = cmd_func;
  end

  assign cmd_ready = !busy_q;
  assign pay_ready = busy_q && link_idle && (left_q != '0);
  assign tx_data   = flit_q;
  assign tx_rdy    = rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      left_q <= '0;
      flit_q <= '0;
    end else if (!busy_q) begin
      if (cmd_valid) begin
        flit_q <= head;
        rdy_q  <= ~rdy_q;
        busy_q <= 1'b1;
        left_q <= (cmd_len > LEN_W'(1)) ? cmd_len - LEN_W'(1) : '0;
      end
    end else if (link_idle) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else if (pay_valid) begin
        flit_q <= pay_data;
        rdy_q  <= ~rdy_q;
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

  // R4: no new flit while the previous one is unacknowledged
  a_r4_hold_rdy: assert property (@(posedge clk) disable iff (rst)
    (tx_rdy != tx_ack) |=> $stable(tx_rdy));
  a_r4_hold_data: assert property (@(posedge clk) disable iff (rst)
    (tx_rdy != tx_ack) |=> $stable(tx_data));
  // R5: an accepted command puts its heading on the link at once
  a_r5_accept_sends: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (tx_rdy != $past(tx_rdy)));
  // R5: the command port only reopens on an idle link
  a_r5_reopen_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ready) |-> (tx_rdy == tx_ack));
endmodule

// File: rtl/nif_rx.sv
module nif_rx
  import nif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic [FLIT_W-1:0] rx_data,
  input  logic              rx_rdy,
  output logic              rx_ack,
  output logic              hdr_valid,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [ID_W-1:0]   hdr_src,
  output logic [LEN_W-1:0]  hdr_len,
  output logic [FUNC_W-1:0] hdr_func,
  output logic              word_valid,
  output logic [FLIT_W-1:0] word_data,
  output logic              word_last,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  rx_state_t         st_q;
  logic              ack_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              pend;
  logic              len_bad;
  logic              dst_bad;
  head_t             head;

  logic              hdr_v_q, word_v_q, last_q, err_v_q;
  logic [1:0]        code_q;
  logic [FLIT_W-1:0] word_q;
  head_t             meta_q;

  assign pend    = (rx_rdy != ack_q);
  assign head    = rx_data;
  assign len_bad = (head.len < LEN_W'(MIN_LEN));
  assign dst_bad = (head.dst != node_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= RX_HEAD;
      ack_q    <= 1'b0;
      cnt_q    <= '0;
      hdr_v_q  <= 1'b0;
      word_v_q <= 1'b0;
      last_q   <= 1'b0;
      err_v_q  <= 1'b0;
      code_q   <= 2'b00;
      word_q   <= '0;
      meta_q   <= '0;
    end else begin
      hdr_v_q  <= 1'b0;
      word_v_q <= 1'b0;
      last_q   <= 1'b0;
      err_v_q  <= 1'b0;
      if (pend) begin
        ack_q <= ~ack_q;
        unique case (st_q)
          RX_HEAD: begin
            if (len_bad || dst_bad) begin
              err_v_q <= 1'b1;
              code_q  <= {dst_bad, len_bad};
              if (!len_bad) begin
                cnt_q <= head.len - LEN_W'(1);
                st_q  <= RX_DROP;
              end
            end else begin
              hdr_v_q <= 1'b1;
              meta_q  <= head;
              cnt_q   <= head.len - LEN_W'(1);
              st_q    <= RX_BODY;
            end
          end
          RX_BODY: begin
            word_v_q <= 1'b1;
            word_q   <= rx_data;
            last_q   <= (cnt_q == LEN_W'(1));
            cnt_q    <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) st_q <= RX_HEAD;
          end
          RX_DROP: begin
            cnt_q <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) st_q <= RX_HEAD;
          end
          default: st_q <= RX_HEAD;
        endcase
      end
    end
  end

  assign rx_ack     = ack_q;
  assign hdr_valid  = hdr_v_q;
  assign hdr_type   = meta_q.mtype;
  assign hdr_src    = meta_q.src;
  assign hdr_len    = meta_q.len;
  assign hdr_func   = meta_q.func;
  assign word_valid = word_v_q;
  assign word_data  = word_q;
  assign word_last  = last_q;
  assign err_valid  = err_v_q;
  assign err_code   = code_q;

  // R6: acknowledge moves only for a pending flit, and always for one
  a_r6_ack_idle: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy == rx_ack) |=> $stable(rx_ack));
  a_r6_ack_taken: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy != rx_ack) |=> (rx_ack != $past(rx_ack)));
  // R8: at most one kind of report per cycle; last marks a real word
  a_r8_one_report: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_valid, word_valid, err_valid}));
  a_r8_last_word: assert property (@(posedge clk) disable iff (rst)
    word_last |-> word_valid);
  // R9: a short heading leaves the receiver waiting for a heading
  a_r9_short_resync: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code[0]) |-> (st_q == RX_HEAD));
  // R10: nothing is delivered while a rejected packet drains
  a_r10_silent_drop: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_DROP) |-> !word_valid);
endmodule

// File: rtl/nif_framer.sv
module nif_framer
  import nif_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic              numa_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [FLIT_W-1:0] pay_data,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_rdy,
  input  logic              tx_ack,
  input  logic [FLIT_W-1:0] rx_data,
  input  logic              rx_rdy,
  output logic              rx_ack,
  output logic              hdr_valid,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [ID_W-1:0]   hdr_src,
  output logic [LEN_W-1:0]  hdr_len,
  output logic [FUNC_W-1:0] hdr_func,
  output logic              word_valid,
  output logic [FLIT_W-1:0] word_data,
  output logic              word_last,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  logic [ID_W-1:0] dst_pick;

  nif_dest_pick #(.ADDR_W(ADDR_W)) u_dest (
    .addr (cmd_addr),
    .numa (numa_mode),
    .dst  (dst_pick)
  );

  nif_tx u_tx (
    .clk       (clk),
    .rst       (rst),
    .node_id   (node_id),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_type  (cmd_type),
    .cmd_dst   (dst_pick),
    .cmd_len   (cmd_len),
    .cmd_func  (cmd_func),
    .pay_valid (pay_valid),
    .pay_ready (pay_ready),
    .pay_data  (pay_data),
    .tx_data   (tx_data),
    .tx_rdy    (tx_rdy),
    .tx_ack    (tx_ack)
  );

  nif_rx u_rx (
    .clk        (clk),
    .rst        (rst),
    .node_id    (node_id),
    .rx_data    (rx_data),
    .rx_rdy     (rx_rdy),
    .rx_ack     (rx_ack),
    .hdr_valid  (hdr_valid),
    .hdr_type   (hdr_type),
    .hdr_src    (hdr_src),
    .hdr_len    (hdr_len),
    .hdr_func   (hdr_func),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_last  (word_last),
    .err_valid  (err_valid),
    .err_code   (err_code)
  );
endmodule

// File: tb/sim_nif_framer.sv
module sim_nif_framer;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  node_id = MY_ID;
  logic        numa_mode = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_type = '0;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic [3:0]  cmd_func = '0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic [31:0] pay_data = '0;
  logic [31:0] tx_data;
  logic        tx_rdy;
  logic        tx_ack = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_rdy = 1'b0;
  logic        rx_ack;
  logic        hdr_valid;
  logic [3:0]  hdr_type;
  logic [7:0]  hdr_src;
  logic [7:0]  hdr_len;
  logic [3:0]  hdr_func;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_last;
  logic        err_valid;
  logic [1:0]  err_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] tx_exp[$];
  string       tx_tag[$];
  logic [34:0] rx_exp[$];
  int          sink_cnt = 0;

  always #4 clk = ~clk;

  nif_framer u0 (.*);

  task automatic check(input bit ok, input string req, input logic [34:0] act,
                       input logic [34:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // network sink on the transmit link: compare, hold, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (tx_rdy != tx_ack)) begin
        logic [31:0] got;
        got = tx_data;
        if (tx_exp.size() == 0) begin
          check(1'b0, "R3 extra flit", {3'b0, got}, '0);
        end else begin
          string t;
          logic [31:0] e;
          e = tx_exp.pop_front();
          t = tx_tag.pop_front();
          check(got == e, t, {3'b0, got}, {3'b0, e});
        end
        repeat (sink_cnt % 3) @(negedge clk);
        sink_cnt++;
        check(tx_data == got, "R4 data held", {3'b0, tx_data}, {3'b0, got});
        if (tx_exp.size() == 0)
          check(cmd_ready == 1'b0, "R5 busy until last ack", {34'b0, cmd_ready}, '0);
        tx_ack = ~tx_ack;
      end
    end
  end

  // receive-side monitor: pops expected reports
  task automatic rx_take(input logic [34:0] got, input string req);
    if (rx_exp.size() == 0) begin
      check(1'b0, {req, " unexpected"}, got, '0);
    end else begin
      logic [34:0] e;
      e = rx_exp.pop_front();
      check(got == e, req, got, e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_valid)  rx_take({2'd0, 9'd0, hdr_type, hdr_src, hdr_len, hdr_func}, "R7");
      if (word_valid) rx_take({2'd1, word_last, word_data}, "R8");
      if (err_valid)  rx_take({2'd2, 31'd0, err_code}, err_code[0] ? "R9" : "R10");
    end
  end

  task automatic send_msg(input logic [3:0] ty, input logic [31:0] addr,
                          input logic numa, input logic [7:0] len,
                          input logic [3:0] fn, input string tag);
    logic [7:0] dst;
    int nw;
    dst = numa ? addr[31:24] : addr[7:0];
    nw  = (len > 1) ? int'(len) - 1 : 0;
    tx_exp.push_back({ty, MY_ID, dst, len, fn});
    tx_tag.push_back(tag);
    for (int i = 0; i < nw; i++) begin
      tx_exp.push_back(32'hA500_0000 + {16'(len), 16'(i)});
      tx_tag.push_back("R3 payload");
    end
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_type = ty; cmd_addr = addr;
    numa_mode = numa; cmd_len = len; cmd_func = fn;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < nw; i++) begin
      pay_valid = 1'b1;
      pay_data  = 32'hA500_0000 + {16'(len), 16'(i)};
      #1;
      while (!pay_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      pay_valid = 1'b0;
    end
    while ((tx_exp.size() != 0) || !cmd_ready) @(negedge clk);
  endtask

  task automatic rx_flit(input logic [31:0] w);
    int waited;
    rx_data = w;
    rx_rdy  = ~rx_rdy;
    waited  = 0;
    do begin
      @(negedge clk);
      waited++;
    end while ((rx_ack != rx_rdy) && (waited < 50));
    check(waited == 1, "R6 ack one cycle", 35'(waited), 35'd1);
  endtask

  task automatic rx_msg(input logic [3:0] ty, input logic [7:0] src,
                        input logic [7:0] dst, input logic [7:0] len,
                        input logic [3:0] fn);
    bit lbad, dbad;
    int nw;
    lbad = (len < 2);
    dbad = (dst != MY_ID);
    nw   = lbad ? 0 : int'(len) - 1;
    if (lbad || dbad) rx_exp.push_back({2'd2, 31'd0, dbad, lbad});
    else begin
      rx_exp.push_back({2'd0, 9'd0, ty, src, len, fn});
      for (int i = 0; i < nw; i++)
        rx_exp.push_back({2'd1, (i == nw - 1), 32'hC0DE_0000 + 32'(i)});
    end
    rx_flit({ty, src, dst, len, fn});
    for (int i = 0; i < nw; i++) rx_flit(32'hC0DE_0000 + 32'(i));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset values
    check(cmd_ready == 1'b1, "R5 reset cmd_ready", {34'b0, cmd_ready}, 35'd1);
    check(tx_rdy == 1'b0, "R5 reset tx_rdy", {34'b0, tx_rdy}, '0);
    check(rx_ack == 1'b0, "R5 reset rx_ack", {34'b0, rx_ack}, '0);
    check(!hdr_valid && !word_valid && !err_valid, "R7 R8 quiet after reset",
          {32'b0, hdr_valid, word_valid, err_valid}, '0);

    // R1 R2 R3: block request, low-address destination
    send_msg(4'h0, 32'h1234_56AB, 1'b0, 8'd2, 4'h3, "R1 heading low mode");
    // R2: block reply, high-address destination, s=4
    send_msg(4'h1, 32'hC300_0011, 1'b1, 8'd6, 4'h9, "R2 heading high mode");
    // R3: heading-only cases
    send_msg(4'h2, 32'h0000_0077, 1'b0, 8'd1, 4'h0, "R3 len one");
    send_msg(4'h3, 32'h9900_0044, 1'b1, 8'd0, 4'hF, "R3 len zero");
    send_msg(4'hF, 32'h8000_00FF, 1'b0, 8'd3, 4'h5, "R1 all fields");

    // receive side
    rx_msg(4'h0, 8'h21, MY_ID, 8'd2, 4'h1);      // R7 R8
    rx_msg(4'h1, 8'h33, MY_ID, 8'd6, 4'hA);      // R8 reply
    rx_msg(4'h2, 8'h44, MY_ID, 8'd1, 4'h0);      // R9 short
    rx_msg(4'h3, 8'h45, 8'h10, 8'd0, 4'h0);      // R9 short and foreign
    rx_msg(4'h1, 8'h46, 8'h10, 8'd4, 4'h2);      // R10 drop three
    rx_msg(4'h0, 8'h47, MY_ID, 8'd3, 4'h7);      // R10 resync afterwards

    repeat (5) @(negedge clk);
    check(tx_exp.size() == 0, "R3 all flits sent", 35'(tx_exp.size()), '0);
    check(rx_exp.size() == 0, "R8 all reports seen", 35'(rx_exp.size()), '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule